// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Flags

This block combines four reset causes into a single active-low system reset: an asynchronous external reset pin, a watchdog overflow pulse, a low-voltage detector trip and an oscillation-stop event from a clock monitor. Each cause is brought into the clock domain through a synchronizer. The system reset is then held for a fixed number of cycles after the last cause goes away. Software reads a three-bit cause register to learn why the chip restarted. Hardware sets a bit when its cause fires. Software clears the bit by writing zero to it.

After every release of the system reset, the block runs a main-oscillator stabilization wait of 2^STAB_LOG2 cycles before it lets the CPU run. If the watchdog overflows inside that wait, the main oscillator is treated as broken. The block then releases the CPU at once on the internal oscillator and enters an emergency mode. In that mode it flags restricted register access and disables serial blocks clocked from outside. Emergency mode survives every reset except the external pin.

The control register of the low-voltage detector gets its own reset output. A reset caused only by the detector leaves that register alone. Every other cause resets it.

Top module: `rst_source_ctrl`

## Requirements
- R1: While `ext_rst_n` is low: `sys_rst_n`=0, `lvd_reg_rst_n`=0, `cpu_run`=0, `rd_flags`=000, `emerg_mode`=0, `clk_sel_int`=0 and `ext_serial_en`=1.
- R2: A reset cause held at least 3 cycles drives `sys_rst_n` low. `sys_rst_n` rises between HOLD_CYCLES+1 and HOLD_CYCLES+5 cycles after the last cause input deasserts.
- R3: Cause flag bit 0 = low-voltage, bit 1 = watchdog (outside the stabilization wait), bit 2 = clock monitor. Hardware sets a bit when its cause fires. Only the external pin clears all bits.
- R4: A cycle with `wr_en`=1 clears every flag bit where `wr_data` is 0. Bits where `wr_data` is 1 keep their value.
- R5: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up 1.
- R6: A reset caused only by the low-voltage detector keeps `lvd_reg_rst_n` high throughout. Clock-monitor and watchdog resets drive it low.
- R7: Outside emergency mode, `cpu_run` rises between 2^STAB_LOG2 and 2^STAB_LOG2+3 cycles after `sys_rst_n` rises, with `clk_sel_int`=0.
- R8: A watchdog overflow during the stabilization wait causes no reset and sets no flag. It raises `cpu_run` within 4 cycles and sets `clk_sel_int`=1, `emerg_mode`=1 and `ext_serial_en`=0.
- R9: Emergency mode persists through non-pin resets, and `cpu_run` then rises within 3 cycles of `sys_rst_n` with no stabilization wait. Only an external pin reset returns the block to normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdt_ovf | input | 1 | Watchdog overflow event |
| lvd_trip | input | 1 | Low-voltage detector trip |
| clkmon_stop | input | 1 | Clock monitor oscillation-stop event |
| wr_en | input | 1 | Cause register write strobe |
| wr_data | input | 3 | Cause register write data (0 clears a bit) |
| rd_flags | output | 3 | Cause register read value |
| sys_rst_n | output | 1 | System reset, active low |
| lvd_reg_rst_n | output | 1 | Reset for the low-voltage detector control register, active low |
| cpu_run | output | 1 | CPU released to execute |
| clk_sel_int | output | 1 | CPU clock select: 1 = internal oscillator |
| emerg_mode | output | 1 | Restricted register access in force |
| ext_serial_en | output | 1 | Enable for serial blocks on external clocks |

## Verification
The bench measures the reset hold and the stabilization wait in cycles. A counter that is off by one, or that ignores the synchronizer latency, then shows up as a duration outside its window. It issues a watchdog pulse inside the wait. A design that treats that pulse as an ordinary reset would pull `sys_rst_n` low and set the watchdog flag, which the bench catches. It keeps clearing a flag while that flag's cause fires. A design where the clear wins would read back 0. It watches `lvd_reg_rst_n` during a reset caused only by the detector, then runs a follow-up detector reset in emergency mode. A design that dropped emergency mode or restarted the wait would show the wrong clock select or a late CPU release.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   typedef enum logic [1:0] {
      PH_HOLD = 2'd0,
      PH_STAB = 2'd1,
      PH_RUN  = 2'd2
   } phase_e;

   localparam int unsigned CAUSE_LVD = 0;
   localparam int unsigned CAUSE_WDT = 1;
   localparam int unsigned CAUSE_CLM = 2;
   localparam int unsigned NUM_CAUSES = 3;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("rstc_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain[0] <= {WIDTH{RST_VAL}};
      else         chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) chain[s] <= {WIDTH{RST_VAL}};
         else         chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
   parameter int unsigned HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic src,
   output logic rst_act
);
   localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
   localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt     <= HOLD_LOAD;
         rst_act <= 1'b1;
      end else begin
         if (src)             cnt <= HOLD_LOAD;
         else if (cnt != '0)  cnt <= cnt - 1'b1;
         rst_act <= src || (cnt != '0);
      end
   end

   // R2: any live cause keeps the system in reset next cycle
   p_src_forces_rst_r2: assert property (@(posedge clk) disable iff (!arst_n)
      src |=> rst_act);
   // R2: release only after a quiet cycle
   p_release_quiet_r2: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(rst_act) |-> !$past(src));
endmodule

// File: rtl/rstc_stab.sv
module rstc_stab
   import rstc_pkg::*;
#(
   parameter int unsigned STAB_LOG2 = 6
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rst_act,
   input  logic wdt_evt,
   output logic stab_phase,
   output logic cpu_run,
   output logic emerg
);
   phase_e               ph;
   logic [STAB_LOG2-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         ph    <= PH_HOLD;
         cnt   <= '0;
         emerg <= 1'b0;
      end else if (rst_act) begin
         ph  <= PH_HOLD;
         cnt <= '0;
      end else begin
         unique case (ph)
            PH_HOLD: begin
               ph  <= emerg ? PH_RUN : PH_STAB;
               cnt <= '0;
            end
            PH_STAB: begin
               if (wdt_evt) begin
                  ph    <= PH_RUN;
                  emerg <= 1'b1;
               end else if (&cnt) begin
                  ph <= PH_RUN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: ph <= PH_RUN;
         endcase
      end
   end

   assign stab_phase = (ph == PH_STAB);
   assign cpu_run    = (ph == PH_RUN) && !rst_act;

   // R8: watchdog inside the wait releases the CPU in emergency mode
   p_wdt_in_wait_r8: assert property (@(posedge clk) disable iff (!arst_n)
      (stab_phase && wdt_evt && !rst_act) |=> (emerg && ph == PH_RUN));
   // R9: emergency mode is sticky until the pin reset
   p_emerg_sticky_r9: assert property (@(posedge clk) disable iff (!arst_n)
      emerg |=> emerg);
endmodule

// File: rtl/rstc_flags.sv
module rstc_flags #(
   parameter int unsigned NF = 3
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic [NF-1:0] set_vec,
   input  logic          wr_en,
   input  logic [NF-1:0] wr_data,
   output logic [NF-1:0] flags
);
   for (genvar i = 0; i < NF; i++) begin : g_bit
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)                      flags[i] <= 1'b0;
         else if (set_vec[i])              flags[i] <= 1'b1;
         else if (wr_en && !wr_data[i])    flags[i] <= 1'b0;
      end

      // R5: a hardware set beats a same-cycle clear
      p_set_wins_r5: assert property (@(posedge clk) disable iff (!arst_n)
         set_vec[i] |=> flags[i]);
      // R4: writing one leaves a set bit set
      p_write_one_keeps_r4: assert property (@(posedge clk) disable iff (!arst_n)
         (wr_en && wr_data[i] && flags[i]) |=> flags[i]);
   end
endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
   import rstc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 16,
   parameter int unsigned STAB_LOG2   = 6
) (
   input  logic       clk,
   input  logic       ext_rst_n,
   input  logic       wdt_ovf,
   input  logic       lvd_trip,
   input  logic       clkmon_stop,
   input  logic       wr_en,
   input  logic [2:0] wr_data,
   output logic [2:0] rd_flags,
   output logic       sys_rst_n,
   output logic       lvd_reg_rst_n,
   output logic       cpu_run,
   output logic       clk_sel_int,
   output logic       emerg_mode,
   output logic       ext_serial_en
);
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("rst_source_ctrl: HOLD_CYCLES must be at least 1");
   end
   if (STAB_LOG2 < 1 || STAB_LOG2 > 24) begin : g_bad_stab
      $error("rst_source_ctrl: STAB_LOG2 out of range");
   end

   logic                  ext_ok;
   logic [NUM_CAUSES-1:0] raw_cause, cause_s, set_vec;
   logic                  stab_phase, rst_act, emerg, wdt_rst, other_now, other_seen;

   rstc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
      .clk(clk), .arst_n(ext_rst_n), .d(1'b1), .q(ext_ok));

   assign raw_cause[CAUSE_LVD] = lvd_trip;
   assign raw_cause[CAUSE_WDT] = wdt_ovf;
   assign raw_cause[CAUSE_CLM] = clkmon_stop;

   rstc_sync #(.WIDTH(NUM_CAUSES), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cause_sync (
      .clk(clk), .arst_n(ext_ok), .d(raw_cause), .q(cause_s));

   assign wdt_rst   = cause_s[CAUSE_WDT] && !stab_phase;
   assign other_now = wdt_rst || cause_s[CAUSE_CLM];

   always_comb begin
      set_vec            = cause_s;
      set_vec[CAUSE_WDT] = wdt_rst;
   end

   rstc_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk(clk), .arst_n(ext_ok),
      .src(cause_s[CAUSE_LVD] || other_now),
      .rst_act(rst_act));

   rstc_stab #(.STAB_LOG2(STAB_LOG2)) u_stab (
      .clk(clk), .arst_n(ext_ok), .rst_act(rst_act),
      .wdt_evt(cause_s[CAUSE_WDT]), .stab_phase(stab_phase),
      .cpu_run(cpu_run), .emerg(emerg));

   rstc_flags #(.NF(NUM_CAUSES)) u_flags (
      .clk(clk), .arst_n(ext_ok), .set_vec(set_vec),
      .wr_en(wr_en), .wr_data(wr_data), .flags(rd_flags));

   // remembers whether the current reset episode had a non-detector cause
   always_ff @(posedge clk or negedge ext_ok) begin
      if (!ext_ok)        other_seen <= 1'b1;
      else if (other_now) other_seen <= 1'b1;
      else if (!rst_act)  other_seen <= 1'b0;
   end

   assign sys_rst_n     = !rst_act;
   assign lvd_reg_rst_n = !(other_now || (other_seen && rst_act));
   assign clk_sel_int   = emerg;
   assign emerg_mode    = emerg;
   assign ext_serial_en = !emerg;

   // R6: clock-monitor or run-time watchdog reset reaches the detector register
   p_other_resets_lvdreg_r6: assert property (@(posedge clk) disable iff (!ext_ok)
      other_now |=> !lvd_reg_rst_n);
   // R7: the CPU never runs while the system reset is asserted
   p_no_run_in_reset_r7: assert property (@(posedge clk) disable iff (!ext_ok)
      !sys_rst_n |-> !cpu_run);
endmodule

// File: tb/rst_source_ctrl_tb.sv
module rst_source_ctrl_tb;
   localparam int HOLD = 16;
   localparam int STABW = 64;

   logic clk = 1'b0;
   logic ext_rst_n = 1'b0, wdt_ovf = 1'b0, lvd_trip = 1'b0, clkmon_stop = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_data = 3'b000;
   logic [2:0] rd_flags;
   logic sys_rst_n, lvd_reg_rst_n, cpu_run, clk_sel_int, emerg_mode, ext_serial_en;

   int checks = 0, failures = 0, n = 0;
   bit done = 0, mon_lvd = 0, lvd_low_seen = 0, mon_sys = 0, sys_low_seen = 0;
   logic [2:0] exp_flags = 3'b000;

   always #2 clk = ~clk;

   rst_source_ctrl #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .STAB_LOG2(6)) u_dut (
      .clk(clk), .ext_rst_n(ext_rst_n), .wdt_ovf(wdt_ovf), .lvd_trip(lvd_trip),
      .clkmon_stop(clkmon_stop), .wr_en(wr_en), .wr_data(wr_data), .rd_flags(rd_flags),
      .sys_rst_n(sys_rst_n), .lvd_reg_rst_n(lvd_reg_rst_n), .cpu_run(cpu_run),
      .clk_sel_int(clk_sel_int), .emerg_mode(emerg_mode), .ext_serial_en(ext_serial_en));

   always @(negedge clk) begin
      if (mon_lvd && !lvd_reg_rst_n) lvd_low_seen = 1;
      if (mon_sys && !sys_rst_n) sys_low_seen = 1;
   end

   function automatic logic [2:0] f_after_write(logic [2:0] old, logic [2:0] d);
      return old & d;
   endfunction
   function automatic logic [2:0] f_after_cause(logic [2:0] old, int src);
      return old | (3'b001 << src);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive_src(int s, logic v);
      case (s)
         0: lvd_trip = v;
         1: wdt_ovf = v;
         default: clkmon_stop = v;
      endcase
   endtask

   task automatic pulse(int s, int w);
      @(posedge clk); #1 drive_src(s, 1'b1);
      repeat (w) @(posedge clk);
      #1 drive_src(s, 1'b0);
   endtask

   task automatic wait_sys(output int cnt);
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!sys_rst_n && cnt < 500);
   endtask

   task automatic wait_run(output int cnt);
      cnt = 0;
      while (!cpu_run && cnt < 1000) begin @(negedge clk); cnt++; end
   endtask

   task automatic reg_write(logic [2:0] d);
      @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
      @(posedge clk); #1 wr_en = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R1: reset state
      repeat (6) @(negedge clk);
      chk(!sys_rst_n && !lvd_reg_rst_n && !cpu_run, "R1 resets asserted", {sys_rst_n, lvd_reg_rst_n, cpu_run}, 0);
      chk(rd_flags == 3'b000 && !emerg_mode && !clk_sel_int && ext_serial_en, "R1 flags/mode", rd_flags, 0);
      @(posedge clk); #1 ext_rst_n = 1'b1;
      wait_sys(n);
      wait_run(n);
      chk(n >= STABW && n <= STABW + 3, "R7 stabilization wait", n, STABW);
      chk(!clk_sel_int && ext_serial_en, "R7 main clock select", clk_sel_int, 0);

      // R2/R3/R6: low-voltage reset
      lvd_low_seen = 0; mon_lvd = 1;
      pulse(0, 4);
      wait_sys(n);
      chk(n >= HOLD + 1 && n <= HOLD + 5, "R2 hold after lvd", n, HOLD + 2);
      wait_run(n);
      mon_lvd = 0;
      chk(!lvd_low_seen, "R6 lvd reg untouched by lvd reset", lvd_low_seen, 0);
      exp_flags = f_after_cause(exp_flags, 0);
      chk(rd_flags == exp_flags, "R3 lvd flag", rd_flags, exp_flags);

      // clock monitor reset
      lvd_low_seen = 0; mon_lvd = 1;
      pulse(2, 3);
      wait_sys(n);
      chk(n >= HOLD + 1 && n <= HOLD + 5, "R2 hold after clkmon", n, HOLD + 2);
      wait_run(n);
      mon_lvd = 0;
      chk(lvd_low_seen, "R6 lvd reg reset by clkmon", lvd_low_seen, 1);
      exp_flags = f_after_cause(exp_flags, 2);
      chk(rd_flags == exp_flags, "R3 clkmon flag", rd_flags, exp_flags);

      // watchdog in run
      lvd_low_seen = 0; mon_lvd = 1;
      pulse(1, 3);
      wait_sys(n);
      wait_run(n);
      mon_lvd = 0;
      chk(lvd_low_seen, "R6 lvd reg reset by watchdog", lvd_low_seen, 1);
      exp_flags = f_after_cause(exp_flags, 1);
      chk(rd_flags == exp_flags, "R3 watchdog flag", rd_flags, exp_flags);

      // R4: write semantics
      reg_write(3'b111); exp_flags = f_after_write(exp_flags, 3'b111);
      chk(rd_flags == exp_flags, "R4 write ones no effect", rd_flags, exp_flags);
      reg_write(3'b110); exp_flags = f_after_write(exp_flags, 3'b110);
      chk(rd_flags == exp_flags, "R4 clear bit0 only", rd_flags, exp_flags);
      reg_write(3'b011); exp_flags = f_after_write(exp_flags, 3'b011);
      chk(rd_flags == exp_flags, "R4 clear bit2 only", rd_flags, exp_flags);

      // R5: set wins over continuous clear
      @(posedge clk); #1 lvd_trip = 1'b1; wr_en = 1'b1; wr_data = 3'b000;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(rd_flags == 3'b001, "R5 set beats clear", rd_flags, 1);
      @(posedge clk); #1 lvd_trip = 1'b0; wr_en = 1'b0;
      wait_sys(n); wait_run(n);
      exp_flags = 3'b001;
      chk(rd_flags == exp_flags, "R5 flag held after overlap", rd_flags, exp_flags);

      // R8: watchdog during stabilization wait
      reg_write(3'b000); exp_flags = 3'b000;
      pulse(2, 3);
      wait_sys(n);
      repeat (8) @(negedge clk);
      sys_low_seen = 0; mon_sys = 1;
      pulse(1, 1);
      wait_run(n);
      chk(n <= 4, "R8 fast release", n, 4);
      repeat (3) @(negedge clk);
      mon_sys = 0;
      chk(!sys_low_seen, "R8 no reset from wait watchdog", sys_low_seen, 0);
      chk(clk_sel_int && emerg_mode && !ext_serial_en, "R8 emergency outputs",
          {clk_sel_int, emerg_mode, ext_serial_en}, 3'b110);
      exp_flags = f_after_cause(exp_flags, 2);
      chk(rd_flags == exp_flags, "R8 no watchdog flag", rd_flags, exp_flags);

      // R9: emergency survives a low-voltage reset
      pulse(0, 3);
      wait_sys(n);
      wait_run(n);
      chk(n <= 3, "R9 no wait in emergency", n, 3);
      chk(emerg_mode && clk_sel_int, "R9 emergency persists", emerg_mode, 1);

      // R9/R1: pin reset leaves emergency
      @(posedge clk); #1 ext_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!emerg_mode && rd_flags == 3'b000 && !sys_rst_n, "R1 pin reset clears", rd_flags, 0);
      @(posedge clk); #1 ext_rst_n = 1'b1;
      wait_sys(n);
      wait_run(n);
      chk(n >= STABW && n <= STABW + 3 && !clk_sel_int, "R9 normal mode after pin", n, STABW);
      exp_flags = 3'b000;

      // random mix
      for (int it = 0; it < 24; it++) begin
         int s, w;
         logic [2:0] d;
         s = $urandom_range(0, 2);
         w = $urandom_range(3, 6);
         pulse(s, w);
         wait_sys(n);
         chk(n >= HOLD + 1 && n <= HOLD + 5, "R2 random hold", n, HOLD + 2);
         wait_run(n);
         exp_flags = f_after_cause(exp_flags, s);
         chk(rd_flags == exp_flags, "R3 random cause", rd_flags, exp_flags);
         d = 3'($urandom_range(0, 7));
         reg_write(d);
         exp_flags = f_after_write(exp_flags, d);
         chk(rd_flags == exp_flags && !emerg_mode, "R4 random write", rd_flags, exp_flags);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule